// File: doc/BRIEF.md
# Converter Sequence Controller

This block drives a 12-bit successive-approximation converter through a programmed run of conversions. Eight slot registers each describe one conversion: the input channel or differential pair, the reference choice, whether acquisition is stretched, and whether the result is packed toward the high or the low end of a 16-bit word. Software picks a first and a last slot and a store index, then writes the go bit. The controller visits the slots in order, waits out each acquisition window measured in converter-clock ticks, pulses a start to the analog side, and files each result into a 16-entry sample buffer.

The converter clock is a tick derived from the system clock by a power-of-two divider. While a run is active, the go bit reads as 1 and every control, address and slot register holds its value. A sticky flag reports that sixteen results have been stored since it was last cleared.

Register map (word index on the register port): 0 control, 1 run address, 8 to 15 slot settings, 16 to 31 the sample buffer (read only, entry = index - 16).

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `seq_busy`, `buf_full` and `conv_start` are 0, and the control, run address and slot registers read as 0.
- R2: A run visits slots from the first slot (run address bits [2:0]) to the last slot (bits [6:4]), adding 1 modulo 8, so a last slot below the first wraps from 7 to 0.
- R3: Slot bits are [2:0] channel code, [3] differential, [4] left alignment, [5] extended acquisition, [6] reference select. A single-ended slot issues `conv_ch` = channel code with `conv_diff` = 0; a differential slot with code bits [1:0] = 00, 01, 10 issues `conv_ch` = 0, 2, 4 (pairs 0/1, 2/3, 4/5) with `conv_diff` = 1; `conv_ref` follows bit [6]. Channel bit [2] is ignored in differential mode.
- R4: A differential slot whose code bits [1:0] are 11 is reserved: it produces no `conv_start` and no buffer write, and the run moves on one cycle after reaching it.
- R5: On entering a slot, `conv_start` rises for exactly one cycle after need x D clock edges, where need is 2 converter-clock ticks, or 16 x (A + 1) ticks when slot bit [5] is set, with A the control field [15:12].
- R6: The converter-clock divisor D is 2 shifted left by the control field [7:6] (2, 4, 8 or 16 system clocks).
- R7: While `seq_busy` is 1, writes to the control, run address and slot registers have no effect.
- R8: Results are stored starting at the store index (run address bits [11:8]); the index increments after each stored result and wraps from 15 to 0.
- R9: With slot bit [4] = 0 the stored word is the 12-bit result in bits [11:0]; with bit [4] = 1 it occupies bits [15:4]; the rest is 0.
- R10: Writing control bit [0] = 1 while idle starts a run; `seq_busy` (also control bit [0] on read) stays 1 until the edge that accepts `conv_done` for the last slot.
- R11: `buf_full` (control bit [1] on read) rises when the 16th result since reset or since the last clear is stored, stays set, and is cleared (with the result count) by writing control bit [1] = 1 while idle.
- R12: A read strobe returns the addressed register or buffer entry on `reg_rdata` in the following cycle, holding until the next strobe; unmapped indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Register write index |
| reg_wdata | input | 16 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_raddr | input | 5 | Register read index |
| reg_rdata | output | 16 | Read data, one cycle after the strobe |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_ch | output | 3 | Input channel, or lower channel of the pair |
| conv_diff | output | 1 | Differential conversion request |
| conv_ref | output | 1 | Reference select for the conversion |
| conv_done | input | 1 | Converter reports a finished conversion |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |
| seq_busy | output | 1 | A run is in progress |
| buf_full | output | 1 | Sixteen results stored since last clear |

## Verification
On every cycle the assertions watch that a start request lasts one cycle and only occurs during a run, that reserved pair codes never reach the converter, that the run address stays frozen while busy, that the store index steps by one per stored result and that the full flag only drops through a clear. Exact acquisition lengths for each divisor and stretch setting, the slot order including wrap-around, the packed buffer contents and the write lock as seen through read-back can only be shown by the bench's scenarios, where a behavioural model predicts every output cycle by cycle against a converter stand-in with varying latency.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int REG_W = 16;

  typedef struct packed {
    logic       ref_sel;
    logic       acq_ext;
    logic       align_left;
    logic       diff;
    logic [2:0] ch;
  } slot_cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV} seq_state_t;

  function automatic logic [REG_W-1:0] place_result(input logic [11:0] r, input logic left);
    return left ? {r, 4'b0000} : {4'b0000, r};
  endfunction

endpackage

// File: rtl/adc_clk_tick.sv
module adc_clk_tick #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int CNT_W = 1 << DIV_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   div_val;
  logic [CNT_W-1:0] lim;

  always_comb begin
    div_val = (CNT_W+1)'(2) << div_sel;
    lim     = CNT_W'(div_val - 1'b1);
    tick    = run && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run)     cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R6: the phase counter never passes the selected divisor
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= lim));

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 3,
  parameter int IDX_W  = 4,
  parameter int DIV_W  = 2,
  parameter int ACQ_W  = 4,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              busy,
  input  logic              full,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DIV_W-1:0]  div_sel,
  output logic [ACQ_W-1:0]  acq_sel,
  output logic [SLOT_W-1:0] seq_first,
  output logic [SLOT_W-1:0] seq_last,
  output logic [IDX_W-1:0]  store_idx,
  output slot_cfg_t         cfg [SLOTS],
  output logic [REG_W-1:0]  reg_q
);
  localparam int CFG_BASE = 8;
  localparam int CFG_W    = $bits(slot_cfg_t);

  logic wr_ok;
  assign wr_ok = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_sel <= '0; acq_sel <= '0;
      seq_first <= '0; seq_last <= '0; store_idx <= '0;
    end else if (wr_ok) begin
      if (wr_addr == AW'(0)) begin
        acq_sel <= wr_data[15:12];
        div_sel <= wr_data[7:6];
      end
      if (wr_addr == AW'(1)) begin
        seq_first <= wr_data[2:0];
        seq_last  <= wr_data[6:4];
        store_idx <= wr_data[11:8];
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                    cfg[s] <= '0;
      else if (wr_ok && wr_addr == AW'(CFG_BASE + s)) cfg[s] <= wr_data[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_q <= '0;
    else if (rd_en) begin
      if (rd_addr == AW'(0))
        reg_q <= {acq_sel, 4'b0000, div_sel, 4'b0000, full, busy};
      else if (rd_addr == AW'(1))
        reg_q <= {4'b0000, store_idx, 1'b0, seq_last, 1'b0, seq_first};
      else if (rd_addr >= AW'(CFG_BASE) && rd_addr < AW'(CFG_BASE + SLOTS))
        reg_q <= REG_W'(cfg[SLOT_W'(rd_addr - AW'(CFG_BASE))]);
      else
        reg_q <= '0;
    end
  end

  // R7: run address and divider stay frozen while a run is active
  a_r7_addr_locked: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(seq_first) && $stable(seq_last) && $stable(store_idx) && $stable(div_sel)));

endmodule

// File: rtl/adc_sample_buf.sv
module adc_sample_buf #(
  parameter int IDX_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int IDX_W    = 4,
  parameter int DIV_W    = 2,
  parameter int ACQ_W    = 4,
  parameter int BASE_ACQ = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [4:0]  reg_waddr,
  input  logic [15:0] reg_wdata,
  input  logic        reg_rd,
  input  logic [4:0]  reg_raddr,
  output logic [15:0] reg_rdata,
  output logic        conv_start,
  output logic [2:0]  conv_ch,
  output logic        conv_diff,
  output logic        conv_ref,
  input  logic        conv_done,
  input  logic [11:0] conv_result,
  output logic        seq_busy,
  output logic        buf_full
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int NEED_W = ACQ_W + 5;
  localparam int AW     = 5;

  seq_state_t        state;
  logic [SLOT_W-1:0] slot, seq_first, seq_last;
  logic [IDX_W-1:0]  widx, store_idx;
  logic [NEED_W-1:0] acnt, need;
  logic [IDX_W:0]    cnt;
  logic [DIV_W-1:0]  div_sel;
  logic [ACQ_W-1:0]  acq_sel;
  slot_cfg_t         cfg [SLOTS];
  slot_cfg_t         cur;
  logic [15:0]       reg_q, buf_q;
  logic              rsel, tick, launch, clr_cnt, reserved, last, advance, enter, buf_we;

  adc_seq_regs #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .DIV_W(DIV_W),
                 .ACQ_W(ACQ_W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
    .busy(seq_busy), .full(buf_full), .rd_en(reg_rd), .rd_addr(reg_raddr),
    .div_sel(div_sel), .acq_sel(acq_sel), .seq_first(seq_first), .seq_last(seq_last),
    .store_idx(store_idx), .cfg(cfg), .reg_q(reg_q));

  adc_clk_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .clear(enter), .run(state == S_ACQ),
    .div_sel(div_sel), .tick(tick));

  adc_sample_buf #(.IDX_W(IDX_W), .DW(16)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .waddr(widx),
    .wdata(place_result(conv_result, cur.align_left)),
    .re(reg_rd && reg_raddr[AW-1]), .raddr(reg_raddr[IDX_W-1:0]), .rdata(buf_q));

  always_comb begin
    cur      = cfg[slot];
    seq_busy = (state != S_IDLE);
    launch   = reg_wr && !seq_busy && reg_waddr == AW'(0) && reg_wdata[0];
    clr_cnt  = reg_wr && !seq_busy && reg_waddr == AW'(0) && reg_wdata[1];
    reserved = cur.diff && (cur.ch[1:0] == 2'b11);
    need     = cur.acq_ext ? NEED_W'((acq_sel + 1'b1) << 4) : NEED_W'(BASE_ACQ);
    last     = (slot == seq_last);
    buf_we   = (state == S_CONV) && conv_done;
    advance  = ((state == S_ACQ) && reserved) || buf_we;
    enter    = launch || (advance && !last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; slot <= '0; widx <= '0; acnt <= '0; cnt <= '0; buf_full <= 1'b0;
      conv_start <= 1'b0; conv_ch <= '0; conv_diff <= 1'b0; conv_ref <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (clr_cnt) begin cnt <= '0; buf_full <= 1'b0; end
          if (launch) begin
            state <= S_ACQ; slot <= seq_first; widx <= store_idx; acnt <= '0;
          end
        end
        S_ACQ: begin
          if (reserved) begin
            if (last) state <= S_IDLE;
            else begin slot <= slot + 1'b1; acnt <= '0; end
          end else if (tick) begin
            if (acnt == need - 1'b1) begin
              state      <= S_CONV;
              conv_start <= 1'b1;
              conv_ch    <= cur.diff ? {cur.ch[1:0], 1'b0} : cur.ch;
              conv_diff  <= cur.diff;
              conv_ref   <= cur.ref_sel;
            end else acnt <= acnt + 1'b1;
          end
        end
        S_CONV: begin
          if (conv_done) begin
            widx <= widx + 1'b1;
            if (cnt != (IDX_W+1)'(DEPTH)) cnt <= cnt + 1'b1;
            if (cnt == (IDX_W+1)'(DEPTH - 1)) buf_full <= 1'b1;
            if (last) state <= S_IDLE;
            else begin state <= S_ACQ; slot <= slot + 1'b1; acnt <= '0; end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rsel <= 1'b0;
    else if (reg_rd) rsel <= reg_raddr[AW-1];
  end
  assign reg_rdata = rsel ? buf_q : reg_q;

  // R5: a start request lasts a single cycle
  a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R10: start requests only occur inside a run
  a_r10_start_in_run: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> seq_busy);
  // R4: a reserved pair code never reaches the converter
  a_r4_no_reserved: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !(conv_diff && conv_ch == 3'd6));
  // R8: the store index steps by one per stored result
  a_r8_widx_step: assert property (@(posedge clk) disable iff (rst)
    buf_we |=> (widx == $past(widx) + 1'b1));
  // R11: the full flag only drops through a clear
  a_r11_full_sticky: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !clr_cnt) |=> buf_full);

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, reg_wr = 0, reg_rd = 0, conv_done = 0;
  logic [4:0]  reg_waddr = 0, reg_raddr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [11:0] conv_result = 0;
  logic        conv_start, conv_diff, conv_ref, seq_busy, buf_full;
  logic [2:0]  conv_ch;

  adc_seq_ctrl dut (.*);

  int checks = 0, errors = 0, n_starts = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int m_state, m_wait, m_slot, m_widx, m_cnt, m_ch, m_diff, m_ref;
  int m_div, m_acq, m_first, m_last, m_store, m_rd;
  int m_cfg[8], m_buf[16];
  bit m_full, m_cs;
  string m_rdtag = "R12";

  function automatic bit is_res(input int c);
    return ((c >> 3) & 1) == 1 && (c & 3) == 3;
  endfunction
  task automatic m_enter();
    int need;
    need = ((m_cfg[m_slot] >> 5) & 1) ? 16 * (m_acq + 1) : 2;
    m_state = 1;
    m_wait = need * (2 << m_div);
  endtask
  task automatic m_adv();
    if (m_slot == m_last) m_state = 0;
    else begin m_slot = (m_slot + 1) % 8; m_enter(); end
  endtask
  function automatic int m_reg(input int a);
    if (a == 0) return (m_acq << 12) | (m_div << 6) | (int'(m_full) << 1) | int'(m_state != 0);
    if (a == 1) return m_first | (m_last << 4) | (m_store << 8);
    if (a >= 8 && a < 16) return m_cfg[a - 8];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_slot = 0; m_widx = 0; m_cnt = 0; m_full = 0; m_cs = 0;
      m_div = 0; m_acq = 0; m_first = 0; m_last = 0; m_store = 0; m_rd = 0;
      m_ch = 0; m_diff = 0; m_ref = 0;
      for (int i = 0; i < 8; i++) m_cfg[i] = 0;
      for (int i = 0; i < 16; i++) m_buf[i] = 0;
    end else begin
      bit busy_pre;
      int c;
      m_cs = 0;
      busy_pre = (m_state != 0);
      if (reg_rd) begin
        if (reg_raddr >= 16) begin m_rd = m_buf[reg_raddr - 16]; m_rdtag = "R8 R9"; end
        else begin m_rd = m_reg(int'(reg_raddr)); m_rdtag = "R12"; end
      end
      c = m_cfg[m_slot];
      if (m_state == 1) begin
        if (is_res(c)) m_adv();
        else begin
          m_wait--;
          if (m_wait == 0) begin
            m_cs = 1; m_state = 2;
            m_diff = (c >> 3) & 1; m_ref = (c >> 6) & 1;
            m_ch = m_diff ? (c & 3) * 2 : (c & 7);
          end
        end
      end else if (m_state == 2 && conv_done) begin
        m_buf[m_widx] = ((c >> 4) & 1) ? (int'(conv_result) << 4) : int'(conv_result);
        m_widx = (m_widx + 1) % 16;
        if (m_cnt < 16) m_cnt++;
        if (m_cnt == 16) m_full = 1;
        m_adv();
      end
      if (reg_wr && !busy_pre) begin
        if (reg_waddr == 1) begin
          m_first = reg_wdata[2:0]; m_last = reg_wdata[6:4]; m_store = reg_wdata[11:8];
        end else if (reg_waddr >= 8 && reg_waddr < 16) m_cfg[reg_waddr - 8] = reg_wdata[6:0];
        else if (reg_waddr == 0) begin
          m_acq = reg_wdata[15:12]; m_div = reg_wdata[7:6];
          if (reg_wdata[1]) begin m_cnt = 0; m_full = 0; end
          if (reg_wdata[0]) begin
            m_slot = m_first; m_widx = m_store; m_enter();
          end
        end
      end
    end
  end

  // cycle-by-cycle comparison
  initial forever @(negedge clk) if (cmp_on) begin
    chk("R10", seq_busy, m_state != 0);
    chk("R11", buf_full, m_full);
    chk("R4 R5 R6", conv_start, m_cs);
    if (m_cs) begin
      n_starts++;
      chk("R2 R3 ch", conv_ch, m_ch);
      chk("R3 diff", conv_diff, m_diff);
      chk("R3 ref", conv_ref, m_ref);
    end
    chk(m_rdtag, reg_rdata, m_rd);
  end

  // converter stand-in with varying latency
  initial begin
    int pend = 0, k = 0;
    forever @(negedge clk) begin
      conv_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          conv_done = 1'b1;
          conv_result = 12'((k * 413 + 'h5A3) & 'hFFF);
          k++;
        end
      end
      if (conv_start) pend = 3 + k % 3;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1; reg_waddr = 5'(a); reg_wdata = 16'(d);
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); reg_rd = 1; reg_raddr = 5'(a);
    @(negedge clk); reg_rd = 0;
    chk(tag, reg_rdata, exp);
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 20000 && seq_busy; i++) @(negedge clk);
  endtask
  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog got busy exp idle");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    chk("R1 busy", seq_busy, 0);
    chk("R1 full", buf_full, 0);
    chk("R1 start", conv_start, 0);
    rd_chk(0, 0, "R1 ctrl");
    rd_chk(1, 0, "R1 addr");
    rd_chk(9, 0, "R1 slot");
    rd_chk(5, 0, "R12 unmapped");
    wr(8, 'h03); wr(9, 'h59); wr(10, 'h0F); wr(11, 'h25);
    wr(12, 'h0C); wr(13, 'h1A); wr(14, 'h40); wr(15, 'h17);
    // run 1: slots 0..3, store 14, div 2, A=1
    wr(1, 'h0E30);
    wr(0, 'h1001);
    wr(1, 'h0777); wr(8, 'h7F); wr(0, 'hF0C1);
    wait_idle();
    chk("R4 starts", n_starts, 3);
    rd_chk(1, 'h0E30, "R7 addr");
    rd_chk(8, 'h03, "R7 slot");
    rd_chk(0, 'h1000, "R7 ctrl");
    rd_chk(16 + 14, 'h05A3, "R8 R9 right");
    rd_chk(16 + 15, 'h7400, "R9 left");
    rd_chk(16 + 0, 'h08DD, "R8 wrap");
    // run 2: slots 6,7,0,1 wrap, store 3, div 16
    wr(1, 'h0316);
    wr(0, 'h00C1);
    wait_idle();
    chk("R2 starts", n_starts, 7);
    // run 3: all slots, div 4, A=15
    wr(1, 'h0770);
    wr(0, 'hF041);
    wait_idle();
    chk("R11 not yet", buf_full, 0);
    // run 4: slots 0..1, store 1
    wr(1, 'h0110);
    wr(0, 'h0001);
    wait_idle();
    chk("R11 full", buf_full, 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); reg_rd = 1; reg_raddr = 5'(16 + i);
    end
    @(negedge clk); reg_rd = 0;
    rd_chk(0, 'h0002, "R11 ctrl");
    wr(0, 'h0002);
    @(negedge clk);
    chk("R11 clear", buf_full, 0);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule